// File: doc/BRIEF.md
# Carry-Select Add-Accumulator

This block keeps a running unsigned total of a stream of 16-bit values, typically the products of an 8-by-8 multiplier. Each value is widened with zeros to the 20-bit accumulator width and added to the current total. The 20-bit adder is split into five equal 4-bit carry-select sections. Each section computes its result for both carry-in values ahead of time. The real carry-in coming from the section below then picks one of the two.

Timing uses both clock edges. When the accumulate command is high on a rising edge, the new sum and its carry out are captured in a staging register. The following falling edge copies them into the total. The adder's feedback input therefore never changes in the same instant that its result is being stored.

A two-state transfer machine links the two edges. It starts in `ST_HOLD`. The transition `HOLD->XFER` happens on a rising edge with the command high. `XFER->XFER` happens on a rising edge with the command still high. `XFER->HOLD` happens on a rising edge with the command low. `HOLD->HOLD` happens on a rising edge with the command low. In `ST_XFER` the falling edge copies the staged sum into the total.

Top module: `csel_accum`

## Requirements
- R1: When `acc_en` is high on a rising edge, the total after the next falling edge equals the old total plus `operand` zero-extended to 20 bits, modulo 2^20.
- R2: Carries must ripple correctly from one 4-bit section to the next, including a carry that crosses several section boundaries at once (for example 0x0FFF + 0x0001 moving into bit 12).
- R3: The total does not change at the rising edge that captures a command. It takes the new value at the falling edge that follows.
- R4: While `rst_n` is low, `total` and `carry_out` are zero right away, without waiting for a clock edge.
- R5: When `acc_en` is low on a rising edge, `total` and `carry_out` keep their values through the next falling edge, whatever `operand` is.
- R6: `carry_out` is bit 20 of the 21-bit sum of the last accepted add. For example, 0xFFFFE plus 0x0002 gives a total of 0x00000 with `carry_out` equal to 1.
- R7: Ten adds of 0xFE01 (255 times 255) after a reset give a total of 0x9EC0A with `carry_out` equal to 0.
- R8: After a reset, five adds of 0x0002 give totals of 2, 4, 6, 8 and 10, in that order.
- R9: A later add that does not wrap returns `carry_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The sum is staged on the rising edge and the total is updated on the falling edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Accumulate command, sampled on the rising edge |
| operand | input | 16 | Unsigned value to add |
| total | output | 20 | Running total |
| carry_out | output | 1 | Carry out of the last accepted 20-bit add |

## Verification
The vector walk picks operands whose carries cross one, two and three section boundaries. An adder that selected the wrong precomputed result, or passed the wrong carry between sections, would be off by a multiple of 16 at those points. A separate check samples the total between the capturing rising edge and the following falling edge. A design that updated the total on the rising edge would already show the new value there. Further tests change `operand` while the command is low, force a 20-bit wrap, and reset in the middle of a run. These catch a total that drifts while idle, a carry that is lost or stays set after a later add, and a reset that waits for a clock edge.

// File: rtl/cs_acc_pkg.sv
package cs_acc_pkg;
    parameter int ACC_W = 20;
    parameter int OP_W  = 16;
    parameter int SEC_W = 4;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_XFER = 1'b1
    } xfer_state_t;
endpackage

// File: rtl/cs_section.sv
module cs_section #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] pre0;
    logic [W:0] pre1;

    // Both candidate results are computed without waiting for the carry in.
    always_comb begin
        pre0 = {1'b0, a} + {1'b0, b};
        pre1 = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
    end

    // The arriving carry only steers the final multiplexer.
    always_comb begin
        if (cin) begin
            sum  = pre1[W-1:0];
            cout = pre1[W];
        end else begin
            sum  = pre0[W-1:0];
            cout = pre0[W];
        end
    end
endmodule

// File: rtl/cs_adder.sv
module cs_adder #(
    parameter int W     = 20,
    parameter int SEC_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NSEC = W / SEC_W;

    logic [NSEC:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar s = 0; s < NSEC; s++) begin : g_sec
            cs_section #(.W(SEC_W)) u_sec (
                .a    (a[s*SEC_W +: SEC_W]),
                .b    (b[s*SEC_W +: SEC_W]),
                .cin  (chain[s]),
                .sum  (sum[s*SEC_W +: SEC_W]),
                .cout (chain[s+1])
            );
        end
    endgenerate

    assign cout = chain[NSEC];
endmodule

// File: rtl/acc_stage.sv
module acc_stage
    import cs_acc_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_en,
    input  logic [W-1:0] sum_in,
    input  logic         cout_in,
    output logic [W-1:0] sum_q,
    output logic         carry_q,
    output logic         xfer
);
    xfer_state_t state;
    xfer_state_t state_nx;

    // State register, rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD: state_nx = acc_en ? ST_XFER : ST_HOLD;
            ST_XFER: state_nx = acc_en ? ST_XFER : ST_HOLD;
            default: state_nx = ST_HOLD;
        endcase
    end

    // Staging register: it captures the adder result only when a command is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else if (acc_en) begin
            sum_q   <= sum_in;
            carry_q <= cout_in;
        end
    end

    // Output decode.
    always_comb begin
        xfer = (state == ST_XFER);
    end
endmodule

// File: rtl/acc_store.sv
module acc_store #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer,
    input  logic [W-1:0] sum_q,
    input  logic         carry_q,
    output logic [W-1:0] total,
    output logic         carry_out
);
    // The falling edge copies the staged sum into the running total.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total     <= '0;
            carry_out <= 1'b0;
        end else if (xfer) begin
            total     <= sum_q;
            carry_out <= carry_q;
        end
    end
endmodule

// File: rtl/csel_accum.sv
module csel_accum
    import cs_acc_pkg::*;
#(
    parameter int ACC_WIDTH = cs_acc_pkg::ACC_W,
    parameter int OP_WIDTH  = cs_acc_pkg::OP_W,
    parameter int SEC_WIDTH = cs_acc_pkg::SEC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic [OP_WIDTH-1:0]  operand,
    output logic [ACC_WIDTH-1:0] total,
    output logic                 carry_out
);
    localparam int PAD_W = ACC_WIDTH - OP_WIDTH;

    logic [ACC_WIDTH-1:0] op_ext;
    logic [ACC_WIDTH-1:0] add_sum;
    logic                 add_cout;
    logic [ACC_WIDTH-1:0] sum_q;
    logic                 carry_q;
    logic                 xfer;

    assign op_ext = {{PAD_W{1'b0}}, operand};

    cs_adder #(.W(ACC_WIDTH), .SEC_W(SEC_WIDTH)) u_add (
        .a    (total),
        .b    (op_ext),
        .sum  (add_sum),
        .cout (add_cout)
    );

    acc_stage #(.W(ACC_WIDTH)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (acc_en),
        .sum_in  (add_sum),
        .cout_in (add_cout),
        .sum_q   (sum_q),
        .carry_q (carry_q),
        .xfer    (xfer)
    );

    acc_store #(.W(ACC_WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .sum_q     (sum_q),
        .carry_q   (carry_q),
        .total     (total),
        .carry_out (carry_out)
    );
endmodule

// File: rtl/csel_accum_chk.sv
module csel_accum_chk #(
    parameter int ACC_WIDTH = 20,
    parameter int OP_WIDTH  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_en,
    input logic [OP_WIDTH-1:0]  operand,
    input logic [ACC_WIDTH-1:0] total,
    input logic                 carry_out
);
    // R4
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (total == '0 && carry_out == 1'b0));

    // R1
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> ({carry_out, total} ==
                    ({1'b0, $past(total)} + {{(ACC_WIDTH-OP_WIDTH+1){1'b0}}, $past(operand)})));

    // R5
    idle_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(total));

    // R5
    idle_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(carry_out));
endmodule

bind csel_accum csel_accum_chk #(.ACC_WIDTH(ACC_WIDTH), .OP_WIDTH(OP_WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .operand   (operand),
    .total     (total),
    .carry_out (carry_out)
);

// File: tb/csel_accum_tb.sv
module csel_accum_tb;
    localparam int NVEC = 12;
    localparam logic [15:0] VOP [NVEC] = '{
        16'h0002, 16'h0002, 16'h0002, 16'h0002, 16'h0002, 16'h0006,
        16'hFFF0, 16'h0FFF, 16'h0001, 16'hFFFF, 16'hF001, 16'h0000};
    localparam logic [19:0] VTOT [NVEC] = '{
        20'h00002, 20'h00004, 20'h00006, 20'h00008, 20'h0000A, 20'h00010,
        20'h10000, 20'h10FFF, 20'h11000, 20'h20FFF, 20'h30000, 20'h30000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [15:0] operand = '0;
    logic [19:0] total;
    logic        carry_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    csel_accum u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .operand   (operand),
        .total     (total),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // A single command: drive it after a falling edge and leave it once the transfer has happened.
    task automatic accumulate(input logic [15:0] op);
        @(negedge clk); #1;
        acc_en  = 1'b1;
        operand = op;
        @(posedge clk);
        @(negedge clk); #1;
        acc_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0;
        #1;
        @(negedge clk); #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #1;
        check("R4 reset total", {carry_out, total}, 21'h0);
        #20;
        rst_n = 1'b1;

        // Vector walk: R8 covers the first five entries, R2 the section-crossing ones, R1 all of them.
        for (int i = 0; i < NVEC; i++) begin
            accumulate(VOP[i]);
            check(i < 5 ? "R8 step" : "R1/R2 vector", {carry_out, total}, {1'b0, VTOT[i]});
        end

        // R3: the total stays unchanged between the capturing rising edge and the next falling edge.
        @(negedge clk); #1;
        acc_en = 1'b1;
        operand = 16'h0010;
        @(posedge clk); #1;
        check("R3 unchanged after rising", {1'b0, total}, 21'h30000);
        @(negedge clk); #1;
        acc_en = 1'b0;
        check("R3 updated after falling", {1'b0, total}, 21'h30010);

        // R5: the total and carry hold while idle, even with a changing operand.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            operand = 16'hA5A5 ^ 16'(k);
        end
        @(negedge clk); #1;
        check("R5 idle hold", {carry_out, total}, {1'b0, 20'h30010});

        // R4: the reset takes effect at once, before any clock edge.
        @(negedge clk); #2;
        rst_n = 1'b0;
        #1;
        check("R4 async clear", {carry_out, total}, 21'h0);
        @(negedge clk); #1;
        rst_n = 1'b1;

        // R6: force a 20-bit wrap.
        for (int k = 0; k < 16; k++) accumulate(16'hFFFF);
        check("R6 pre-wrap", {carry_out, total}, {1'b0, 20'hFFFF0});
        accumulate(16'h000E);
        check("R6 reach FFFFE", {carry_out, total}, {1'b0, 20'hFFFFE});
        accumulate(16'h0002);
        check("R6 wrap carry", {carry_out, total}, {1'b1, 20'h00000});
        repeat (3) @(negedge clk);
        check("R5 carry held", {carry_out, total}, {1'b1, 20'h00000});
        accumulate(16'h0001);
        check("R9 carry clears", {carry_out, total}, {1'b0, 20'h00001});

        // R7: ten maximum products.
        do_reset();
        check("R4 reset before max", {carry_out, total}, 21'h0);
        for (int k = 0; k < 10; k++) accumulate(16'hFE01);
        check("R7 ten max products", {carry_out, total}, {1'b0, 20'h9EC0A});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule